// File: doc/BRIEF.md
# Stub Block Packet Concentrator

This block collects track-stub candidates from eight front-end chips on every bunch crossing and packs them into synchronous blocks of fixed length. Each block covers eight consecutive crossings. When a block closes it is sent as one packet on a parallel word stream, so trigger data always leaves with the same latency however many stubs arrived.

Each crossing cycle, every chip can offer at most one stub: a valid flag, an 8-bit strip address and a 5-bit bend value. The crossing counter is sampled at the first crossing of each block and becomes the block's timestamp. A block keeps at most twelve stubs. They are ordered by crossing first and then by ascending chip index. Any stub beyond the twelfth is discarded and counted in the header. Slots that hold no stub are sent as zero. The header also carries a fixed sync pattern and an even-parity bit over the block contents.

The output is two 20-bit lanes wide. One packet takes seven beats. The first beat is marked by a frame strobe and carries the header in its upper lane.

Top module: `stub_block_packer`

## Requirements
- R1: Crossing cycles are numbered from the first clock after reset is released, and block k covers cycles 8k to 8k+7. The packet of block k starts in cycle 8k+8 and ends before the next packet starts, so a frame strobe occurs every 8 cycles.
- R2: A packet is 7 consecutive beats with `vld_o` high. `frame_o` is high only on the first beat. When `vld_o` is low, `data_o` is zero.
- R3: The header word is the upper lane (`data_o[39:20]`) of the first beat. Its fields are: bits [19:18] the sync pattern 2'b10, bit [17] parity, bits [16:13] the number of stored stubs, bits [12:9] the number of dropped stubs, and bits [8:0] the value of `bx_i` at the block's first crossing.
- R4: A stored stub word has bit [19] = 1, bits [18:16] = crossing offset within the block (0..7), bits [15:13] = chip index, bits [12:8] = bend and bits [7:0] = strip.
- R5: Stub slots are filled in order of crossing, then of ascending chip index within a crossing. Packet slot 0 is the header and slot s+1 holds stub s. Beat b carries slot 2b in its upper lane and slot 2b+1 in its lower lane.
- R6: At most 12 stubs are stored per block. Later stubs are dropped, and the dropped count saturates at 15.
- R7: Unused stub slots, and the lower lane of the last beat, are all zero.
- R8: The parity bit equals the XOR of all bits of the twelve stub slots and of the count, dropped and timestamp fields.
- R9: While reset is held and in the first cycles after it, `vld_o`, `frame_o` and `data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_i | input | 9 | Bunch crossing counter |
| stub_vld_i | input | 8 | Per-chip stub present this crossing |
| stub_strip_i | input | 64 | Per-chip strip address, chip c at [8c+7:8c] |
| stub_bend_i | input | 40 | Per-chip bend, chip c at [5c+4:5c] |
| frame_o | output | 1 | First beat of a packet |
| vld_o | output | 1 | Packet beat present |
| data_o | output | 40 | Two packet slots, upper lane first |

## Verification
The hardest case to reach is overflow. The twelfth slot has to fill partway through a crossing, so that lower chips in that crossing are kept and higher ones are dropped. The dropped count also has to reach its saturation point. The bench drives whole blocks of stimulus built from patterns. One block offers all eight chips in two crossings, so the cut falls at chip 3 of the second crossing. Another block offers exactly thirteen stubs, one beyond capacity. A block with every chip active on every crossing drives the dropped count past 15.

// File: rtl/stub_pkt_pkg.sv
package stub_pkt_pkg;
    localparam int STRIP_W = 8;
    localparam int BEND_W  = 5;
    localparam int SYNC_W  = 2;
    localparam logic [SYNC_W-1:0] SYNC_PAT = 2'b10;
endpackage

// File: rtl/stub_slot_alloc.sv
// Ranks this crossing's stubs behind those already stored in the block.
module stub_slot_alloc #(
    parameter int N_CHIPS   = 8,
    parameter int MAX_STUBS = 12,
    parameter int CNT_W     = 4,
    parameter int IDX_W     = 4
) (
    input  logic [N_CHIPS-1:0]       vld_i,
    input  logic [CNT_W-1:0]         base_i,
    output logic [N_CHIPS*IDX_W-1:0] idx_o,
    output logic [N_CHIPS-1:0]       take_o,
    output logic [CNT_W-1:0]         cnt_o,
    output logic [CNT_W-1:0]         over_o
);
    always_comb begin
        int rank;
        int ovr;
        rank   = int'(base_i);
        ovr    = 0;
        idx_o  = '0;
        take_o = '0;
        for (int c = 0; c < N_CHIPS; c++) begin
            if (vld_i[c]) begin
                if (rank < MAX_STUBS) begin
                    take_o[c] = 1'b1;
                    idx_o[c*IDX_W +: IDX_W] = IDX_W'(rank);
                    rank = rank + 1;
                end else begin
                    ovr = ovr + 1;
                end
            end
        end
        cnt_o  = CNT_W'(rank);
        over_o = CNT_W'(ovr);
    end
endmodule

// File: rtl/stub_frame_parity.sv
module stub_frame_parity #(
    parameter int NSLOT   = 12,
    parameter int ENTRY_W = 20,
    parameter int CNT_W   = 4,
    parameter int TS_W    = 9
) (
    input  logic [NSLOT*ENTRY_W-1:0] slots_i,
    input  logic [CNT_W-1:0]         cnt_i,
    input  logic [CNT_W-1:0]         drop_i,
    input  logic [TS_W-1:0]          ts_i,
    output logic                     par_o
);
    assign par_o = (^slots_i) ^ (^cnt_i) ^ (^drop_i) ^ (^ts_i);
endmodule

// File: rtl/stub_beat_mux.sv
module stub_beat_mux #(
    parameter int W       = 20,
    parameter int N_BEATS = 7,
    parameter int BEAT_W  = 3
) (
    input  logic [2*N_BEATS*W-1:0] frame_i,
    input  logic [BEAT_W-1:0]      beat_i,
    input  logic                   act_i,
    output logic [2*W-1:0]         data_o,
    output logic                   frame_o,
    output logic                   vld_o
);
    always_comb begin
        int b;
        b = int'(beat_i);
        data_o = '0;
        if (act_i) data_o = {frame_i[2*b*W +: W], frame_i[(2*b+1)*W +: W]};
    end
    assign frame_o = act_i && (beat_i == '0);
    assign vld_o   = act_i;
endmodule

// File: rtl/stub_block_packer.sv
module stub_block_packer
    import stub_pkt_pkg::*;
#(
    parameter int N_CHIPS   = 8,
    parameter int BLOCK_BX  = 8,
    parameter int MAX_STUBS = 12,
    localparam int PH_W    = $clog2(BLOCK_BX),
    localparam int CHIP_W  = $clog2(N_CHIPS),
    localparam int CNT_W   = $clog2(MAX_STUBS + 1),
    localparam int ENTRY_W = 1 + PH_W + CHIP_W + BEND_W + STRIP_W,
    localparam int TS_W    = ENTRY_W - SYNC_W - 1 - 2*CNT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [TS_W-1:0]             bx_i,
    input  logic [N_CHIPS-1:0]          stub_vld_i,
    input  logic [N_CHIPS*STRIP_W-1:0]  stub_strip_i,
    input  logic [N_CHIPS*BEND_W-1:0]   stub_bend_i,
    output logic                        frame_o,
    output logic                        vld_o,
    output logic [2*ENTRY_W-1:0]        data_o
);
    localparam int IDX_W    = $clog2(MAX_STUBS);
    localparam int N_BEATS  = (MAX_STUBS + 2) / 2;
    localparam int NFR      = 2 * N_BEATS;
    localparam int BEAT_W   = (N_BEATS > 1) ? $clog2(N_BEATS) : 1;
    localparam int DROP_MAX = 2**CNT_W - 1;

    typedef struct packed {
        logic [PH_W-1:0]              ph;
        logic [CNT_W-1:0]             cnt;
        logic [CNT_W-1:0]             drop;
        logic [TS_W-1:0]              ts;
        logic [MAX_STUBS*ENTRY_W-1:0] slots;
        logic [NFR*ENTRY_W-1:0]       obuf;
        logic [BEAT_W-1:0]            beat;
        logic                         act;
    } st_t;

    st_t q, d;

    logic                         first_bx;
    logic [CNT_W-1:0]             base_cnt;
    logic [N_CHIPS*IDX_W-1:0]     slot_idx;
    logic [N_CHIPS-1:0]           take;
    logic [CNT_W-1:0]             cnt_after;
    logic [CNT_W-1:0]             n_over;
    logic [MAX_STUBS*ENTRY_W-1:0] fill;
    logic [CNT_W-1:0]             drop_sat;
    logic [TS_W-1:0]              ts_cur;
    logic                         par;

    assign first_bx = (q.ph == '0);
    assign base_cnt = first_bx ? '0 : q.cnt;
    assign ts_cur   = first_bx ? bx_i : q.ts;

    stub_slot_alloc #(
        .N_CHIPS(N_CHIPS), .MAX_STUBS(MAX_STUBS), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) alloc_i (
        .vld_i(stub_vld_i), .base_i(base_cnt), .idx_o(slot_idx),
        .take_o(take), .cnt_o(cnt_after), .over_o(n_over)
    );

    // Place accepted stubs and accumulate the dropped count.
    always_comb begin
        int dsum;
        fill = first_bx ? '0 : q.slots;
        for (int c = 0; c < N_CHIPS; c++) begin
            if (take[c]) begin
                fill[int'(slot_idx[c*IDX_W +: IDX_W])*ENTRY_W +: ENTRY_W] =
                    {1'b1, q.ph, CHIP_W'(c),
                     stub_bend_i[c*BEND_W +: BEND_W],
                     stub_strip_i[c*STRIP_W +: STRIP_W]};
            end
        end
        dsum = (first_bx ? 0 : int'(q.drop)) + int'(n_over);
        drop_sat = (dsum > DROP_MAX) ? CNT_W'(DROP_MAX) : CNT_W'(dsum);
    end

    stub_frame_parity #(
        .NSLOT(MAX_STUBS), .ENTRY_W(ENTRY_W), .CNT_W(CNT_W), .TS_W(TS_W)
    ) par_i (
        .slots_i(fill), .cnt_i(cnt_after), .drop_i(drop_sat),
        .ts_i(ts_cur), .par_o(par)
    );

    always_comb begin
        d       = q;
        d.ph    = (q.ph == PH_W'(BLOCK_BX - 1)) ? '0 : q.ph + 1'b1;
        d.cnt   = cnt_after;
        d.drop  = drop_sat;
        d.ts    = ts_cur;
        d.slots = fill;
        if (q.act) begin
            if (q.beat == BEAT_W'(N_BEATS - 1)) d.act = 1'b0;
            else                                d.beat = q.beat + 1'b1;
        end
        if (q.ph == PH_W'(BLOCK_BX - 1)) begin
            d.obuf = '0;
            d.obuf[ENTRY_W-1:0] = {SYNC_PAT, par, cnt_after, drop_sat, ts_cur};
            d.obuf[ENTRY_W +: MAX_STUBS*ENTRY_W] = fill;
            d.beat = '0;
            d.act  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    stub_beat_mux #(
        .W(ENTRY_W), .N_BEATS(N_BEATS), .BEAT_W(BEAT_W)
    ) mux_i (
        .frame_i(q.obuf), .beat_i(q.beat), .act_i(q.act),
        .data_o(data_o), .frame_o(frame_o), .vld_o(vld_o)
    );
endmodule

// File: rtl/stub_pkt_checker.sv
module stub_pkt_checker #(
    parameter int W         = 20,
    parameter int BLOCK_BX  = 8,
    parameter int MAX_STUBS = 12,
    parameter int CNT_W     = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         frame_o,
    input logic         vld_o,
    input logic [2*W-1:0] data_o
);
    localparam int N_BEATS = (MAX_STUBS + 2) / 2;
    localparam int CW = 8;

    logic [CW-1:0] since_rst;
    logic [CW-1:0] gap;
    logic [CW-1:0] bcnt;
    logic          seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            gap       <= '0;
            bcnt      <= '0;
            seen      <= 1'b0;
        end else begin
            if (since_rst != '1) since_rst <= since_rst + 1'b1;
            if (frame_o) begin
                gap  <= 8'd1;
                seen <= 1'b1;
                bcnt <= 8'd1;
            end else begin
                if (gap != '1) gap <= gap + 1'b1;
                if (vld_o) bcnt <= bcnt + 1'b1;
            end
        end
    end

    assert_first_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_o && !seen) |-> (since_rst == CW'(BLOCK_BX)));
    assert_frame_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_o && seen) |-> (gap == CW'(BLOCK_BX)));
    assert_strobe_in_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> vld_o);
    assert_rise_is_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vld_o) |-> frame_o);
    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> (data_o == '0));
    assert_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> (data_o[2*W-1 -: 2] == 2'b10));
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> (data_o[W+2*CNT_W+TS_OFF-1 -: CNT_W] <= CNT_W'(MAX_STUBS)));
    assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_o && data_o[W+CNT_W+TS_OFF-1 -: CNT_W] != '0)
            |-> (data_o[W+2*CNT_W+TS_OFF-1 -: CNT_W] == CNT_W'(MAX_STUBS)));
    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !frame_o && bcnt == CW'(N_BEATS - 1)) |-> (data_o[W-1:0] == '0));

    localparam int TS_OFF = W - 3 - 2*CNT_W;
endmodule

bind stub_block_packer stub_pkt_checker #(
    .W(ENTRY_W), .BLOCK_BX(BLOCK_BX), .MAX_STUBS(MAX_STUBS), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .frame_o(frame_o), .vld_o(vld_o), .data_o(data_o)
);

// File: tb/stub_block_packer_tb.sv
module stub_block_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bx_i = '0;
    logic [7:0]  stub_vld_i = '0;
    logic [63:0] stub_strip_i = '0;
    logic [39:0] stub_bend_i = '0;
    logic        frame_o, vld_o;
    logic [39:0] data_o;

    int total = 0;
    int bad = 0;
    int bx = 9'h1FC;
    bit finished = 0;
    logic [19:0] ex [14];

    always #5 clk = ~clk;

    stub_block_packer dut_i (
        .clk(clk), .rst_n(rst_n), .bx_i(bx_i), .stub_vld_i(stub_vld_i),
        .stub_strip_i(stub_strip_i), .stub_bend_i(stub_bend_i),
        .frame_o(frame_o), .vld_o(vld_o), .data_o(data_o)
    );

    function automatic bit hit(int mode, int x, int c);
        case (mode)
            1: return (x == 1 && (c == 5 || c == 2)) || (x == 4 && c == 0) || (x == 7 && c == 7);
            2: return (x == 0) || (x == 2) || (x == 5 && c == 3);
            3: return 1'b1;
            4: return (x == 3) || (x == 6 && c < 4);
            5: return (x == 3) || (x == 6 && c < 4) || (x == 7 && c == 0);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] strip_of(int mode, int x, int c);
        return 8'((x * 37 + c * 11 + mode * 5 + 3) & 255);
    endfunction

    function automatic logic [4:0] bend_of(int mode, int x, int c);
        return 5'((x * 3 + c * 7 + mode + 1) & 31);
    endfunction

    task automatic check(bit ok, string req, logic [39:0] act, logic [39:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drives one block of stimulus, then checks the packet during the next block.
    task automatic run_block(int mode, string name);
        int n = 0;
        int drop = 0;
        logic [8:0] ts;
        logic p;
        ts = 9'(bx);
        for (int s = 0; s < 14; s++) ex[s] = '0;
        for (int x = 0; x < 8; x++) begin
            bx_i = 9'(bx);
            for (int c = 0; c < 8; c++) begin
                stub_vld_i[c] = hit(mode, x, c);
                stub_strip_i[c*8 +: 8] = strip_of(mode, x, c);
                stub_bend_i[c*5 +: 5] = bend_of(mode, x, c);
                if (hit(mode, x, c)) begin
                    if (n < 12) begin
                        ex[n + 1] = {1'b1, 3'(x), 3'(c), bend_of(mode, x, c), strip_of(mode, x, c)};
                        n++;
                    end else if (drop < 15) drop++;
                end
            end
            bx++;
            @(negedge clk);
        end
        p = ^ts ^ ^4'(n) ^ ^4'(drop);
        for (int s = 1; s <= 12; s++) p = p ^ (^ex[s]);
        ex[0] = {2'b10, p, 4'(n), 4'(drop), ts};
        for (int b = 0; b < 8; b++) begin
            if (b < 7) begin
                check(vld_o && (frame_o == (b == 0)), $sformatf("R1/R2 %s beat %0d strobes", name, b),
                      {38'd0, vld_o, frame_o}, {38'd0, 1'b1, b == 0});
                check(data_o[39:20] == ex[2*b],
                      $sformatf("%s %s slot %0d", (b == 0) ? "R3/R6/R8" : "R4/R5/R7", name, 2*b),
                      {20'd0, data_o[39:20]}, {20'd0, ex[2*b]});
                check(data_o[19:0] == ex[2*b+1],
                      $sformatf("%s %s slot %0d", (b == 6) ? "R7" : "R4/R5/R6", name, 2*b+1),
                      {20'd0, data_o[19:0]}, {20'd0, ex[2*b+1]});
            end else begin
                check(!vld_o && !frame_o && data_o == '0, $sformatf("R1/R2 %s gap", name),
                      {vld_o, frame_o, data_o[37:0]}, 40'd0);
            end
            stub_vld_i = '0;
            bx_i = 9'(bx);
            bx++;
            @(negedge clk);
        end
    endtask

    task automatic reset_check();
        repeat (3) @(negedge clk);
        check(!vld_o && !frame_o && data_o == '0, "R9 reset state",
              {vld_o, frame_o, data_o[37:0]}, 40'd0);
    endtask

    initial begin
        reset_check();
        rst_n = 1'b1;
        run_block(0, "empty");
        run_block(1, "sparse order R5");
        run_block(4, "exactly twelve R6");
        run_block(5, "thirteen R6");
        run_block(2, "mid-crossing overflow R6");
        run_block(3, "saturating drop R6");
        run_block(1, "repeat sparse");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule